// File: doc/BRIEF.md
# Frame Start/Done Control Register File

This block is a memory-mapped register file on an AXI4-Lite slave port. A processor uses it to describe a frame job, start the job, and learn when the job is complete. The registers are eight 32-bit words at byte offsets 0x00 to 0x1C. Word 0 holds the job setup fields and a start strobe. Word 1 is a status word with a completion flag. Words 2 to 7 hold byte-wide threshold bounds for the colour-test stages.

Every stored field drives a parallel output. The logic side therefore sees the frame size, a per-stage enable vector and the bound bytes without any further decoding. Writing a 1 into the start strobe produces a one-cycle `start_o` pulse. The strobe reads back as 0. When the logic side pulses `done_i`, the completion flag is set, and software can poll for it. The next start request clears the flag again.

Top module: `frame_ctrl_regs`

## Requirements
- R1: After a synchronous reset, every word reads as zero. The setup, enable and bound outputs are zero and `start_o` is low.
- R2: Word 0 holds the frame width in bits 31:23, the frame height in bits 22:14 and a 6-bit stage-enable field in bits 6:1. These fields appear on `img_width_o`, `img_height_o` and `stage_en_o`. Bits 13:7 are not stored and read as zero.
- R3: A write to word 0 with byte lane 0 enabled and bit 0 set raises `start_o` for exactly one clock. That clock is the one in which the write response is first presented. Bit 0 of word 0 always reads as 0.
- R4: Bit 0 of word 1 is the completion flag. It is set in the clock after `done_i` is sampled high and stays set. A start request clears it. Bits 31:1 read as zero, and writes to word 1 change nothing.
- R5: Words 2 to 7 store all 32 bits. Word k appears on `bound_o[(k-2)*32 +: 32]`. Each bound is one byte. Within a word, the low and high bound of one channel share a 16-bit half, with the low bound in the lower byte. Word 2 holds red in bits 15:0 and green in bits 31:16. Word 3 holds blue and hue. Word 4 holds saturation and value.
- R6: Write strobes act per byte. A byte whose strobe is 0 keeps its old value. A start request needs strobe bit 0 to be set.
- R7: A byte address of 0x20 or above writes nothing and reads as zero. The response to such an access is still OKAY.
- R8: BVALID and RVALID stay high with unchanged data until they are accepted. Every response is OKAY. Each channel holds at most one transaction, so AWREADY and WREADY are low while a write response is pending. AW and W may arrive in either order.
- R9: Address bits 1:0 are ignored, so any byte address inside a word selects that word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_awaddr | input | ADDR_W | Write address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | 32 | Write data |
| s_wstrb | input | 4 | Write byte strobes |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response (always OKAY) |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | ADDR_W | Read address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response (always OKAY) |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| img_width_o | output | 9 | Frame width field |
| img_height_o | output | 9 | Frame height field |
| stage_en_o | output | 6 | Per-stage enable bits |
| bound_o | output | 192 | Bound words 2..7, concatenated |
| start_o | output | 1 | One-cycle start pulse |
| done_i | input | 1 | Completion pulse from the logic side |

## Verification
Suppose the start logic enters a wrong state. The fault then shows on `start_o` as a pulse that is two cycles wide, missing, or not aligned with the write response. It becomes visible in the same cycle as the response to the start write. A stuck or stale completion flag shows on the very next read of word 1, after either a `done_i` pulse or a start request. A corrupted byte merge, or a wrong decode of a word index, shows on the parallel outputs one clock after the write. It also shows on the read-back of the word, so every write that is followed by a read exposes the fault within a few cycles.

// File: rtl/frame_ctrl_pkg.sv
package frame_ctrl_pkg;
  localparam int DATA_W    = 32;
  localparam int STRB_W    = DATA_W / 8;
  localparam int NUM_WORDS = 8;
  localparam int IDX_W     = $clog2(NUM_WORDS);
  localparam int OFF_W     = IDX_W + 2;
  localparam int BOUND_FIRST = 2;
  localparam int NUM_BOUND   = NUM_WORDS - BOUND_FIRST;

  localparam int WID_W = 9;
  localparam int HGT_W = 9;
  localparam int OPS_W = 6;
  localparam int WID_LSB = DATA_W - WID_W;
  localparam int HGT_LSB = WID_LSB - HGT_W;
  localparam int OPS_LSB = 1;

  // stored bits of the setup word: width, height, stage enables
  localparam logic [DATA_W-1:0] SETUP_KEEP =
    (((DATA_W'(1) << (WID_W + HGT_W)) - 1) << HGT_LSB) |
    (((DATA_W'(1) << OPS_W) - 1) << OPS_LSB);

  localparam logic [1:0] RESP_OKAY = 2'b00;

  typedef struct packed {
    logic             hit;
    logic [IDX_W-1:0] idx;
  } reg_sel_t;

  function automatic logic [DATA_W-1:0] byte_merge(
    input logic [DATA_W-1:0] old_v,
    input logic [DATA_W-1:0] new_v,
    input logic [STRB_W-1:0] strb);
    logic [DATA_W-1:0] r;
    for (int b = 0; b < STRB_W; b++)
      r[b*8 +: 8] = strb[b] ? new_v[b*8 +: 8] : old_v[b*8 +: 8];
    return r;
  endfunction
endpackage

// File: rtl/ctrl_axil_wr.sv
module ctrl_axil_wr
  import frame_ctrl_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   s_awaddr,
  input  logic                s_awvalid,
  output logic                s_awready,
  input  logic [DATA_W-1:0]   s_wdata,
  input  logic [STRB_W-1:0]   s_wstrb,
  input  logic                s_wvalid,
  output logic                s_wready,
  output logic [1:0]          s_bresp,
  output logic                s_bvalid,
  input  logic                s_bready,
  output logic                wr_en_o,
  output reg_sel_t            wr_sel_o,
  output logic [DATA_W-1:0]   wr_data_o,
  output logic [STRB_W-1:0]   wr_strb_o
);
  logic                    aw_have, w_have, bvalid_q;
  logic [ADDR_W-1:0]       aw_q;
  logic [DATA_W-1:0]       data_q;
  logic [STRB_W-1:0]       strb_q;
  logic                    unused_lowbits;

  assign unused_lowbits = &{1'b0, aw_q[1:0]};

  assign s_awready = !aw_have && !bvalid_q;
  assign s_wready  = !w_have  && !bvalid_q;
  assign s_bvalid  = bvalid_q;
  assign s_bresp   = RESP_OKAY;

  assign wr_en_o        = aw_have && w_have && !bvalid_q;
  assign wr_sel_o.hit   = (aw_q[ADDR_W-1:OFF_W] == '0);
  assign wr_sel_o.idx   = aw_q[OFF_W-1:2];
  assign wr_data_o      = data_q;
  assign wr_strb_o      = strb_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      aw_have  <= 1'b0;
      w_have   <= 1'b0;
      bvalid_q <= 1'b0;
      aw_q     <= '0;
      data_q   <= '0;
      strb_q   <= '0;
    end else begin
      if (s_awvalid && s_awready) begin
        aw_have <= 1'b1;
        aw_q    <= s_awaddr;
      end
      if (s_wvalid && s_wready) begin
        w_have <= 1'b1;
        data_q <= s_wdata;
        strb_q <= s_wstrb;
      end
      if (wr_en_o) begin
        aw_have  <= 1'b0;
        w_have   <= 1'b0;
        bvalid_q <= 1'b1;
      end else if (bvalid_q && s_bready) begin
        bvalid_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ctrl_axil_rd.sv
module ctrl_axil_rd
  import frame_ctrl_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   s_araddr,
  input  logic                s_arvalid,
  output logic                s_arready,
  output logic [DATA_W-1:0]   s_rdata,
  output logic [1:0]          s_rresp,
  output logic                s_rvalid,
  input  logic                s_rready,
  output reg_sel_t            rd_sel_o,
  input  logic [DATA_W-1:0]   rd_data_i
);
  logic              rvalid_q;
  logic [DATA_W-1:0] rdata_q;
  logic              unused_lowbits;

  assign unused_lowbits = &{1'b0, s_araddr[1:0]};

  assign s_arready    = !rvalid_q;
  assign s_rvalid     = rvalid_q;
  assign s_rdata      = rdata_q;
  assign s_rresp      = RESP_OKAY;
  assign rd_sel_o.hit = (s_araddr[ADDR_W-1:OFF_W] == '0);
  assign rd_sel_o.idx = s_araddr[OFF_W-1:2];

  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else if (s_arvalid && s_arready) begin
      rvalid_q <= 1'b1;
      rdata_q  <= rd_data_i;
    end else if (rvalid_q && s_rready) begin
      rvalid_q <= 1'b0;
    end
  end
endmodule

// File: rtl/ctrl_reg_bank.sv
module ctrl_reg_bank
  import frame_ctrl_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_en_i,
  input  reg_sel_t                      wr_sel_i,
  input  logic [DATA_W-1:0]             wr_data_i,
  input  logic [STRB_W-1:0]             wr_strb_i,
  input  reg_sel_t                      rd_sel_i,
  output logic [DATA_W-1:0]             rd_data_o,
  input  logic                          done_i,
  output logic                          start_o,
  output logic [DATA_W-1:0]             setup_o,
  output logic [NUM_BOUND*DATA_W-1:0]   bound_o
);
  logic [DATA_W-1:0] setup_q;
  logic [DATA_W-1:0] bound_q [NUM_BOUND];
  logic              start_q, done_q;
  logic              setup_wr, start_req;

  assign setup_wr  = wr_en_i && wr_sel_i.hit && (wr_sel_i.idx == IDX_W'(0));
  assign start_req = setup_wr && wr_strb_i[0] && wr_data_i[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      setup_q <= '0;
      start_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      if (setup_wr)
        setup_q <= byte_merge(setup_q, wr_data_i, wr_strb_i) & SETUP_KEEP;
      start_q <= start_req;
      if (start_req)   done_q <= 1'b0;
      else if (done_i) done_q <= 1'b1;
    end
  end

  for (genvar k = 0; k < NUM_BOUND; k++) begin : g_bound
    always_ff @(posedge clk) begin
      if (rst)
        bound_q[k] <= '0;
      else if (wr_en_i && wr_sel_i.hit && (wr_sel_i.idx == IDX_W'(k + BOUND_FIRST)))
        bound_q[k] <= byte_merge(bound_q[k], wr_data_i, wr_strb_i);
    end
    assign bound_o[k*DATA_W +: DATA_W] = bound_q[k];
  end

  always_comb begin
    rd_data_o = '0;
    if (rd_sel_i.hit) begin
      if (rd_sel_i.idx == IDX_W'(0))
        rd_data_o = setup_q;
      else if (rd_sel_i.idx == IDX_W'(1))
        rd_data_o = {{(DATA_W-1){1'b0}}, done_q};
      else
        rd_data_o = bound_q[rd_sel_i.idx - IDX_W'(BOUND_FIRST)];
    end
  end

  assign start_o = start_q;
  assign setup_o = setup_q;
endmodule

// File: rtl/frame_ctrl_regs.sv
module frame_ctrl_regs
  import frame_ctrl_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [ADDR_W-1:0]           s_awaddr,
  input  logic                        s_awvalid,
  output logic                        s_awready,
  input  logic [31:0]                 s_wdata,
  input  logic [3:0]                  s_wstrb,
  input  logic                        s_wvalid,
  output logic                        s_wready,
  output logic [1:0]                  s_bresp,
  output logic                        s_bvalid,
  input  logic                        s_bready,
  input  logic [ADDR_W-1:0]           s_araddr,
  input  logic                        s_arvalid,
  output logic                        s_arready,
  output logic [31:0]                 s_rdata,
  output logic [1:0]                  s_rresp,
  output logic                        s_rvalid,
  input  logic                        s_rready,
  output logic [8:0]                  img_width_o,
  output logic [8:0]                  img_height_o,
  output logic [5:0]                  stage_en_o,
  output logic [191:0]                bound_o,
  output logic                        start_o,
  input  logic                        done_i
);
  reg_sel_t          wr_sel, rd_sel;
  logic              wr_en;
  logic [DATA_W-1:0] wr_data, rd_data, setup;
  logic [STRB_W-1:0] wr_strb;

  ctrl_axil_wr #(.ADDR_W(ADDR_W)) u_wr (
    .clk(clk), .rst(rst),
    .s_awaddr(s_awaddr), .s_awvalid(s_awvalid), .s_awready(s_awready),
    .s_wdata(s_wdata), .s_wstrb(s_wstrb), .s_wvalid(s_wvalid), .s_wready(s_wready),
    .s_bresp(s_bresp), .s_bvalid(s_bvalid), .s_bready(s_bready),
    .wr_en_o(wr_en), .wr_sel_o(wr_sel), .wr_data_o(wr_data), .wr_strb_o(wr_strb)
  );

  ctrl_axil_rd #(.ADDR_W(ADDR_W)) u_rd (
    .clk(clk), .rst(rst),
    .s_araddr(s_araddr), .s_arvalid(s_arvalid), .s_arready(s_arready),
    .s_rdata(s_rdata), .s_rresp(s_rresp), .s_rvalid(s_rvalid), .s_rready(s_rready),
    .rd_sel_o(rd_sel), .rd_data_i(rd_data)
  );

  ctrl_reg_bank u_bank (
    .clk(clk), .rst(rst),
    .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data), .wr_strb_i(wr_strb),
    .rd_sel_i(rd_sel), .rd_data_o(rd_data),
    .done_i(done_i), .start_o(start_o),
    .setup_o(setup), .bound_o(bound_o)
  );

  assign img_width_o  = setup[WID_LSB +: WID_W];
  assign img_height_o = setup[HGT_LSB +: HGT_W];
  assign stage_en_o   = setup[OPS_LSB +: OPS_W];
endmodule

// File: rtl/frame_ctrl_regs_chk.sv
module frame_ctrl_regs_chk (
  input logic        clk,
  input logic        rst,
  input logic        s_awready,
  input logic        s_wready,
  input logic [1:0]  s_bresp,
  input logic        s_bvalid,
  input logic        s_bready,
  input logic [31:0] s_rdata,
  input logic [1:0]  s_rresp,
  input logic        s_rvalid,
  input logic        s_rready,
  input logic        start_o
);
  assert_start_one_cycle_R3: assert property (@(posedge clk) disable iff (rst)
    start_o |=> !start_o);

  assert_start_with_resp_R3: assert property (@(posedge clk) disable iff (rst)
    start_o |-> s_bvalid);

  assert_bvalid_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (s_bvalid && !s_bready) |=> s_bvalid);

  assert_rvalid_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (s_rvalid && !s_rready) |=> (s_rvalid && $stable(s_rdata)));

  assert_okay_resp_R8: assert property (@(posedge clk) disable iff (rst)
    (s_bvalid |-> s_bresp == 2'b00) and (s_rvalid |-> s_rresp == 2'b00));

  assert_one_write_R8: assert property (@(posedge clk) disable iff (rst)
    s_bvalid |-> (!s_awready && !s_wready));
endmodule

bind frame_ctrl_regs frame_ctrl_regs_chk u_chk (
  .clk(clk), .rst(rst),
  .s_awready(s_awready), .s_wready(s_wready),
  .s_bresp(s_bresp), .s_bvalid(s_bvalid), .s_bready(s_bready),
  .s_rdata(s_rdata), .s_rresp(s_rresp), .s_rvalid(s_rvalid), .s_rready(s_rready),
  .start_o(start_o)
);

// File: tb/frame_ctrl_regs_tb.sv
module frame_ctrl_regs_tb;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [7:0]   s_awaddr = '0;
  logic         s_awvalid = 1'b0;
  logic         s_awready;
  logic [31:0]  s_wdata = '0;
  logic [3:0]   s_wstrb = '0;
  logic         s_wvalid = 1'b0;
  logic         s_wready;
  logic [1:0]   s_bresp;
  logic         s_bvalid;
  logic         s_bready = 1'b0;
  logic [7:0]   s_araddr = '0;
  logic         s_arvalid = 1'b0;
  logic         s_arready;
  logic [31:0]  s_rdata;
  logic [1:0]   s_rresp;
  logic         s_rvalid;
  logic         s_rready = 1'b0;
  logic [8:0]   img_width_o;
  logic [8:0]   img_height_o;
  logic [5:0]   stage_en_o;
  logic [191:0] bound_o;
  logic         start_o;
  logic         done_i = 1'b0;

  int total = 0;
  int bad = 0;
  int start_cnt = 0;
  int run_len = 0;
  int max_run = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  frame_ctrl_regs u_dut (.*);

  always @(negedge clk) begin
    if (rst) begin
      run_len <= 0;
    end else if (start_o) begin
      start_cnt <= start_cnt + 1;
      run_len   <= run_len + 1;
      if (run_len + 1 > max_run) max_run <= run_len + 1;
    end else begin
      run_len <= 0;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic axi_write(input logic [7:0] a, input logic [31:0] d, input logic [3:0] s,
                           input int aw_dly, input int w_dly);
    bit aw_done = 0, w_done = 0, aw_hit = 0, w_hit = 0;
    int cyc = 0;
    s_awaddr = a; s_wdata = d; s_wstrb = s;
    while (!(aw_done && w_done)) begin
      @(negedge clk);
      if (aw_hit) begin s_awvalid = 1'b0; aw_done = 1; end
      if (w_hit)  begin s_wvalid  = 1'b0; w_done  = 1; end
      if (!aw_done && cyc >= aw_dly) s_awvalid = 1'b1;
      if (!w_done  && cyc >= w_dly)  s_wvalid  = 1'b1;
      aw_hit = s_awvalid && s_awready;
      w_hit  = s_wvalid && s_wready;
      cyc++;
    end
    s_bready = 1'b1;
    while (!s_bvalid) @(negedge clk);
    check("R8 bresp", {30'd0, s_bresp}, 32'd0);
    @(negedge clk);
    s_bready = 1'b0;
  endtask

  task automatic axi_read(input logic [7:0] a, input int hold, output logic [31:0] d);
    logic [31:0] first;
    @(negedge clk);
    s_araddr = a; s_arvalid = 1'b1;
    while (!s_arready) @(negedge clk);
    @(negedge clk);
    s_arvalid = 1'b0;
    first = s_rdata;
    repeat (hold) @(negedge clk);
    if (hold > 0) begin
      check("R8 rvalid held", {31'd0, s_rvalid}, 32'd1);
      check("R8 rdata stable", s_rdata, first);
    end
    check("R8 rresp", {30'd0, s_rresp}, 32'd0);
    d = s_rdata;
    s_rready = 1'b1;
    @(negedge clk);
    s_rready = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] s);
    axi_write(a, d, s, 0, 0);
  endtask

  task automatic rd_check(input string tag, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] v;
    axi_read(a, 0, v);
    check(tag, v, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] shadow [8];
    logic [31:0] v;
    int sc;
    for (int i = 0; i < 8; i++) shadow[i] = '0;

    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state
    for (int i = 0; i < 8; i++) rd_check("R1 reset word", 8'(i*4), 32'd0);
    check("R1 width", {23'd0, img_width_o}, 32'd0);
    check("R1 height", {23'd0, img_height_o}, 32'd0);
    check("R1 enables", {26'd0, stage_en_o}, 32'd0);
    check("R1 bounds", {31'd0, |bound_o}, 32'd0);
    check("R1 no start", start_cnt, 0);

    // R2: setup word fields, full sweep of the enable field
    for (int op = 0; op < 64; op++) begin
      logic [8:0] w9, h9;
      logic [31:0] wv, ev;
      w9 = 9'((op * 37 + 3) % 512);
      h9 = 9'((op * 113 + 200) % 512);
      wv = {w9, h9, 7'h7F, 6'(op), 1'b0};
      ev = {w9, h9, 7'h00, 6'(op), 1'b0};
      wr(8'h00, wv, 4'hF);
      check("R2 width out", {23'd0, img_width_o}, {23'd0, w9});
      check("R2 height out", {23'd0, img_height_o}, {23'd0, h9});
      check("R2 enable out", {26'd0, stage_en_o}, 32'(op));
      rd_check("R2 readback", 8'h00, ev);
      shadow[0] = ev;
    end
    check("R2 no start from sweep", start_cnt, 0);

    // R3: start pulse
    sc = start_cnt;
    wr(8'h00, shadow[0] | 32'd1, 4'hF);
    check("R3 one pulse", start_cnt, sc + 1);
    check("R3 width one", max_run, 1);
    rd_check("R3 bit0 reads zero", 8'h00, shadow[0]);
    // R6: start needs strobe lane 0
    sc = start_cnt;
    wr(8'h00, 32'hFFFF_FFFF, 4'hE);
    check("R6 no start without lane0", start_cnt, sc);
    shadow[0] = (32'hFFFF_FFFF & 32'hFFFF_C07E & 32'hFFFF_FF00) | (shadow[0] & 32'h0000_00FF);
    rd_check("R6 setup lane merge", 8'h00, shadow[0]);

    // R4: done handshake
    rd_check("R4 done clear after start", 8'h04, 32'd0);
    @(negedge clk); done_i = 1'b1;
    @(negedge clk); done_i = 1'b0;
    rd_check("R4 done set", 8'h04, 32'd1);
    repeat (5) @(negedge clk);
    rd_check("R4 done sticky", 8'h04, 32'd1);
    wr(8'h04, 32'h0000_0000, 4'hF);
    rd_check("R4 write ignored", 8'h04, 32'd1);
    wr(8'h04, 32'hFFFF_FFFE, 4'hF);
    rd_check("R4 reserved zero", 8'h04, 32'd1);
    sc = start_cnt;
    wr(8'h00, shadow[0] | 32'd1, 4'h1);
    check("R4 restart pulse", start_cnt, sc + 1);
    rd_check("R4 cleared by start", 8'h04, 32'd0);

    // R5/R6: bound words, every strobe pattern
    for (int k = 2; k < 8; k++) begin
      for (int s = 0; s < 16; s++) begin
        logic [31:0] base, nv, ev;
        base = 32'(k * 32'h0101_0101) ^ 32'hA5C3_0F96;
        nv   = ~base ^ 32'(s * 32'h0011_2233);
        wr(8'(k*4), base, 4'hF);
        wr(8'(k*4), nv, 4'(s));
        for (int b = 0; b < 4; b++)
          ev[b*8 +: 8] = s[b] ? nv[b*8 +: 8] : base[b*8 +: 8];
        check("R6 bound out merge", bound_o[(k-2)*32 +: 32], ev);
        rd_check("R5 bound readback", 8'(k*4), ev);
        shadow[k] = ev;
      end
    end
    // R5: named bytes of word 2
    wr(8'h08, 32'h4433_2211, 4'hF);
    shadow[2] = 32'h4433_2211;
    check("R5 red low", {24'd0, bound_o[7:0]}, 32'h11);
    check("R5 green high", {24'd0, bound_o[31:24]}, 32'h44);

    // R7: out of range
    wr(8'h20, 32'hDEAD_BEEF, 4'hF);
    wr(8'h40, 32'hDEAD_BEEF, 4'hF);
    wr(8'hFC, 32'hDEAD_BEEF, 4'hF);
    rd_check("R7 read 0x20", 8'h20, 32'd0);
    rd_check("R7 read 0xFC", 8'hFC, 32'd0);
    for (int i = 2; i < 8; i++) rd_check("R7 bounds untouched", 8'(i*4), shadow[i]);
    rd_check("R7 setup untouched", 8'h00, shadow[0]);

    // R8: ordering and hold
    axi_write(8'h0C, 32'h1357_9BDF, 4'hF, 0, 3);
    rd_check("R8 aw first", 8'h0C, 32'h1357_9BDF);
    axi_write(8'h10, 32'h2468_ACE0, 4'hF, 4, 0);
    rd_check("R8 w first", 8'h10, 32'h2468_ACE0);
    axi_read(8'h0C, 3, v);
    check("R8 held read data", v, 32'h1357_9BDF);

    // R9: low address bits ignored
    wr(8'h17, 32'hCAFE_F00D, 4'hF);
    rd_check("R9 write via 0x17", 8'h14, 32'hCAFE_F00D);
    rd_check("R9 read via 0x16", 8'h16, 32'hCAFE_F00D);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule